// File: doc/BRIEF.md
# Switch Processor Port with Indirect Channel Addressing

This block lets a byte-wide host bus reach the memories of a time-slot switch as if they were a plain memory peripheral. Only six address lines are used. When the top address line is low, every access lands on a single mode register. When it is high, the five low lines pick one of 32 channels. The memory and the serial stream behind those 32 channels come from fields held in the mode register. The mode register also carries a split flag: with it set, reads go to the receive data memory and writes go to the low byte of the connection memory. It also carries a global message flag, which is passed on to the serial side.

The host pins are a chip select (active low), a data strobe (active high), a read/write line (high means read) and an acknowledge (active low, open drain, modelled here as a low-active output). These pins are sampled on the block clock. A write to the mode register is acknowledged straight away. Every other access first asks the memory arbiter for a slot, so that it never collides with serial-side memory traffic. The memory strobe fires only in the cycle the slot is granted, and the acknowledge follows. The acknowledge is held until the host drops its strobe or its chip select.

Top module: `swx_host_port`

## Requirements
- R1: With addr[5]=0 the access targets the mode register, whatever addr[4:0] hold.
- R2: With addr[5]=1 and split off, the memory port carries mem_sel = mode[4:3] (01 data memory, 10 connection low, 11 connection high, 00 none) and mem_addr = {mode[1:0], addr[4:0]}.
- R3: With mode[7]=1, reads use mem_sel=01 and writes use mem_sel=10, whatever mode[4:3] hold.
- R4: Mode register bits 5 and 2 always read back as 0. Output glob_msg equals mode[6].
- R5: An access exists only while cs_n=0 and dstb=1. rd_wr=1 means read and rd_wr=0 means write. Without an access, no request, strobe or acknowledge is produced.
- R6: A mode-register write drives ack_n low on the cycle after the first sampling edge, and raises no mem_req.
- R7: Any other access raises mem_req from the cycle after it is sampled. It pulses mem_rd_stb or mem_wr_stb only in a cycle where mem_grant=1, and drives ack_n low the cycle after that grant.
- R8: ack_n returns high the cycle after cs_n rises or dstb falls. A held access produces exactly one memory strobe.
- R9: A write with mem_sel 01, or any access with mem_sel 00, issues no memory strobe but is still acknowledged. A read of sel 00 returns 0.
- R10: On a granted read, rdata takes mem_rdata (or the mode register for addr[5]=0) and holds it until the next granted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| dstb | input | 1 | Data strobe, active high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Host address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| ack_n | output | 1 | Acknowledge, active low |
| glob_msg | output | 1 | Global message flag from mode register |
| mem_req | output | 1 | Request for a memory slot |
| mem_grant | input | 1 | Slot granted this cycle |
| mem_rd_stb | output | 1 | Memory read strobe |
| mem_wr_stb | output | 1 | Memory write strobe |
| mem_sel | output | 2 | Target memory select |
| mem_addr | output | 7 | Stream and channel address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
If the mode register holds a wrong value, the next strobe goes out with the wrong mem_sel or mem_addr, or the next mode read-back returns the wrong byte. Either shows up within one access. A handshake state machine stuck in the wrong state shows up within a cycle as a request with no access, an early or missing acknowledge, or a second strobe during one held access. A bad read-data register shows on rdata as soon as the acknowledge goes low.

// File: rtl/swx_port_pkg.sv
package swx_port_pkg;
  localparam int ADDR_W  = 6;
  localparam int CHAN_W  = ADDR_W - 1;
  localparam int DATA_W  = 8;
  localparam int STRM_W  = 2;
  localparam int MADDR_W = STRM_W + CHAN_W;

  typedef enum logic [1:0] {HS_IDLE = 2'd0, HS_WAIT = 2'd1, HS_DONE = 2'd2} hs_state_t;

  localparam logic [1:0] SEL_NONE = 2'b00;
  localparam logic [1:0] SEL_DM   = 2'b01;
  localparam logic [1:0] SEL_CML  = 2'b10;

  // bits 5 and 2 of the mode register are not stored
  localparam logic [DATA_W-1:0] MODE_MASK = 8'hDB;

  function automatic logic [1:0] eff_sel(input logic [DATA_W-1:0] mode, input logic is_wr);
    if (mode[7]) return is_wr ? SEL_CML : SEL_DM;
    return mode[4:3];
  endfunction

  function automatic logic sel_legal(input logic [1:0] sel, input logic is_wr);
    return (sel != SEL_NONE) && !(sel == SEL_DM && is_wr);
  endfunction
endpackage

// File: rtl/swx_mode_reg.sv
module swx_mode_reg
  import swx_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode <= '0;
    else if (wr_en) mode <= wr_val & MODE_MASK;
  end

  p_mode_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mode == ($past(wr_val) & MODE_MASK)));
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode));
endmodule

// File: rtl/swx_hs_fsm.sv
module swx_hs_fsm
  import swx_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic fast,
  input  logic grant,
  output logic req,
  output logic fire,
  output logic fast_wr,
  output logic ack_n
);
  hs_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      HS_IDLE: if (active) st_nx = fast ? HS_DONE : HS_WAIT;
      HS_WAIT: if (!active) st_nx = HS_IDLE;
               else if (grant) st_nx = HS_DONE;
      HS_DONE: if (!active) st_nx = HS_IDLE;
      default: st_nx = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= HS_IDLE;
    else        st <= st_nx;
  end

  assign req     = (st == HS_WAIT);
  assign fire    = (st == HS_WAIT) && active && grant;
  assign fast_wr = (st == HS_IDLE) && active && fast;
  assign ack_n   = (st != HS_DONE);

  p_fast_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fast_wr |=> !ack_n && !req);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> ack_n && !req);
  p_grant_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !ack_n);
  p_one_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/swx_host_port.sv
module swx_host_port
  import swx_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               dstb,
  input  logic               rd_wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               ack_n,
  output logic               glob_msg,
  output logic               mem_req,
  input  logic               mem_grant,
  output logic               mem_rd_stb,
  output logic               mem_wr_stb,
  output logic [1:0]         mem_sel,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata
);
  logic              active, is_wr, to_mode, legal, fire, fast_wr;
  logic [DATA_W-1:0] mode;

  assign active  = !cs_n && dstb;
  assign is_wr   = !rd_wr;
  assign to_mode = !addr[ADDR_W-1];

  swx_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(fast_wr), .wr_val(wdata), .mode(mode)
  );

  swx_hs_fsm u_hs (
    .clk(clk), .rst_n(rst_n), .active(active), .fast(to_mode && is_wr),
    .grant(mem_grant), .req(mem_req), .fire(fire), .fast_wr(fast_wr), .ack_n(ack_n)
  );

  assign mem_sel    = to_mode ? SEL_NONE : eff_sel(mode, is_wr);
  assign legal      = sel_legal(mem_sel, is_wr);
  assign mem_addr   = {mode[STRM_W-1:0], addr[CHAN_W-1:0]};
  assign mem_wdata  = wdata;
  assign mem_rd_stb = fire && !to_mode && !is_wr && legal;
  assign mem_wr_stb = fire && !to_mode &&  is_wr && legal;
  assign glob_msg   = mode[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (fire && !is_wr) begin
      if (to_mode)    rdata <= mode;
      else if (legal) rdata <= mem_rdata;
      else            rdata <= '0;
    end
  end

  p_strobe_granted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_stb || mem_wr_stb) |-> mem_req && mem_grant);
  p_no_dm_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_stb |-> mem_sel != SEL_DM);
  p_split_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[7] && (mem_rd_stb || mem_wr_stb)) |-> (mem_sel == (mem_wr_stb ? SEL_CML : SEL_DM)));
  p_no_access_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mem_rd_stb && !mem_wr_stb);
  p_excl_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_stb && mem_wr_stb));
endmodule

// File: tb/sim_swx_host_port.sv
module sim_swx_host_port;
  localparam int TCLK = 10;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, dstb = 0, rd_wr = 1, gnt = 0;
  logic [5:0] addr = 0;
  logic [7:0] wdata = 0, mrd = 0;
  logic [7:0] rdata, mem_wdata;
  logic ack_n, glob_msg, mem_req, mem_rd_stb, mem_wr_stb;
  logic [1:0] mem_sel;
  logic [6:0] mem_addr;

  int vecs = 0, bad = 0, cyc = 0;
  int mst = 0;
  logic [7:0] mmode = 0, mrdata = 0;

  always #(TCLK/2) clk = ~clk;

  swx_host_port u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dstb(dstb), .rd_wr(rd_wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ack_n(ack_n), .glob_msg(glob_msg),
    .mem_req(mem_req), .mem_grant(gnt), .mem_rd_stb(mem_rd_stb), .mem_wr_stb(mem_wr_stb),
    .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mrd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // one clock: inputs already set at negedge; compare, then advance model
  task automatic step();
    bit act, mode_acc, wr, ok, fire;
    int esel;
    #1;
    act = !cs_n && dstb;
    mode_acc = (addr[5] == 1'b0);
    wr = (rd_wr == 1'b0);
    if (mode_acc) esel = 0;
    else if (mmode[7]) esel = wr ? 2 : 1;
    else esel = mmode[4:3];
    ok = (esel != 0) && !(esel == 1 && wr);
    fire = (mst == 1) && act && gnt;
    chk("R6/R7/R8 ack_n", ack_n, (mst == 2) ? 0 : 1);
    chk("R5/R7 mem_req", mem_req, (mst == 1) ? 1 : 0);
    chk("R7/R9 mem_rd_stb", mem_rd_stb, (fire && !mode_acc && !wr && ok) ? 1 : 0);
    chk("R7/R9 mem_wr_stb", mem_wr_stb, (fire && !mode_acc && wr && ok) ? 1 : 0);
    chk("R10 rdata", rdata, mrdata);
    chk("R4 glob_msg", glob_msg, mmode[6]);
    if (mem_rd_stb || mem_wr_stb) begin
      chk("R2/R3 mem_sel", mem_sel, esel);
      chk("R2 mem_addr", mem_addr, {mmode[1:0], addr[4:0]});
      if (wr) chk("R2 mem_wdata", mem_wdata, wdata);
    end
    @(posedge clk);
    case (mst)
      0: if (act) begin
           if (mode_acc && wr) begin mmode = wdata & 8'b1101_1011; mst = 2; end
           else mst = 1;
         end
      1: if (!act) mst = 0;
         else if (gnt) begin
           mst = 2;
           if (!wr) mrdata = mode_acc ? mmode : (ok ? mrd : 8'h00);
         end
      default: if (!act) mst = 0;
    endcase
    @(negedge clk);
    cyc++;
    gnt = (cyc % 3 == 2);
  endtask

  task automatic access(input bit rd, input logic [5:0] a, input logic [7:0] d, input int hold);
    cs_n = 0; dstb = 1; rd_wr = rd; addr = a; wdata = d;
    for (int i = 0; i < hold; i++) step();
    dstb = 0;
    step();
    cs_n = 1;
    step();
  endtask

  initial begin
    #(TCLK*50000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R5 reset ack_n", ack_n, 1);
    chk("R10 reset rdata", rdata, 0);
    rst_n = 1;
    step(); step();
    // R5: strobe without select, select without strobe
    cs_n = 1; dstb = 1; rd_wr = 0; addr = 6'h00; wdata = 8'hFF; step(); step();
    cs_n = 0; dstb = 0; step(); step(); cs_n = 1;
    chk("R5 mode untouched", glob_msg, 0);
    // R1/R4: mode writes at different low address bits, readback masks bits 5,2
    access(0, 6'h1F, 8'hFF, 3);
    chk("R4 glob_msg set", glob_msg, 1);
    access(1, 6'h05, 8'h00, 6);
    chk("R1/R4 mode readback", rdata, 8'hDB);
    // R2: connection low, stream 2
    access(0, 6'h00, 8'h12, 2);
    mrd = 8'h5A; access(0, 6'h25, 8'hA7, 6);
    mrd = 8'h3C; access(1, 6'h25, 8'h00, 6);
    chk("R10 read value", rdata, 8'h3C);
    // connection high, stream 3; long hold R8
    access(0, 6'h00, 8'h1B, 2);
    mrd = 8'h81; access(1, 6'h3F, 8'h00, 12);
    chk("R10 conn high read", rdata, 8'h81);
    access(0, 6'h20, 8'h44, 12);
    // R9: data memory write ignored; data memory read works
    access(0, 6'h00, 8'h09, 2);
    access(0, 6'h2A, 8'hEE, 6);
    mrd = 8'h77; access(1, 6'h2A, 8'h00, 6);
    chk("R9/R10 dm read", rdata, 8'h77);
    // R9: sel 00 read returns zero
    access(0, 6'h00, 8'h01, 2);
    mrd = 8'hFF; access(1, 6'h31, 8'h00, 6);
    chk("R9 sel00 read zero", rdata, 8'h00);
    access(0, 6'h31, 8'h99, 6);
    // R3: split mode, sel field says conn high but routing overrides
    access(0, 6'h00, 8'h9A, 2);
    mrd = 8'hC5; access(1, 6'h2E, 8'h00, 6);
    chk("R3 split read", rdata, 8'hC5);
    access(0, 6'h2E, 8'h6D, 6);
    // R8: strobe dropped before grant
    cs_n = 0; dstb = 1; rd_wr = 1; addr = 6'h22; gnt = 0;
    step(); dstb = 0; step(); cs_n = 1; step();
    // mode read goes through slot
    access(1, 6'h1A, 8'h00, 6);
    chk("R1/R4 split mode readback", rdata, 8'h9A);
    step(); step();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule